// File: doc/BRIEF.md
# Working Register and Indirect Data RAM

This block holds a 64-entry by 8-bit data store for a small controller core and gives it three ways in. The bottom eight entries double as the working registers, so an instruction may name one of them with a 3-bit register operand and read or write it directly. Any of the 64 entries can also be reached indirectly. In that case the address comes from the current contents of working register 0 or working register 1, chosen by a single select bit.

A third operation supports loop control. In one cycle it takes a working register, presents its value decremented by one, and raises a flag when that new value is not zero. The decremented value is stored on the same clock edge. A loop-closing branch can use the flag directly.

Reads are combinational from the resolved address. Writes happen on the rising clock edge. Every operation finishes in the cycle it is presented, so the block never applies back-pressure and has no valid/ready pair. The operation code is a plain control input, and a NOP code means no operation this cycle.

Top module: `wreg_ram_unit`

## Requirements
- R1: After the active-low reset, every one of the 64 locations reads 0x00 and `nz_flag` is low.
- R2: Operation code 1 (register read) places location `reg_sel` on `rd_data` in the same cycle. Operation code 2 (register write) stores `wr_data` there at the next rising edge.
- R3: Operation code 3 (indirect read) and operation code 4 (indirect write) address the location named by working register 0 when `ind_sel`=0, or by working register 1 when `ind_sel`=1. Every location 0 to 63 can be reached this way.
- R4: Indirect addressing uses only bits 5:0 of the pointer register. Bits 7:6 have no effect on which location is chosen.
- R5: An indirect access whose pointer holds 0 to 7 reaches the working register with that number. A value written this way reads back through a direct register read.
- R6: During a write (codes 2 and 4), `rd_data` shows the target location's content from before the write. This allows read-then-modify in one cycle.
- R7: Operation code 5 (decrement-and-test) drives `rd_data` with the current value of working register `reg_sel`. It drives `nz_flag` high exactly when that value minus one is nonzero, and stores the decremented value at the next edge.
- R8: Decrement-and-test on a register holding 0x00 stores 0xFF and reports `nz_flag` high.
- R9: Operation code 0 and the unused codes 6 and 7 change no location, whatever `wr_data` holds. They drive `rd_data` to 0x00 and `nz_flag` low. `nz_flag` is low for every code other than 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all locations |
| op | input | 3 | Operation code: 0 none, 1 reg read, 2 reg write, 3 indirect read, 4 indirect write, 5 decrement-and-test |
| reg_sel | input | 3 | Working register number for direct and decrement operations |
| ind_sel | input | 1 | Pointer choice for indirect operations: 0 uses register 0, 1 uses register 1 |
| wr_data | input | 8 | Data to store for write operations |
| rd_data | output | 8 | Content of the addressed location, pre-write value |
| nz_flag | output | 1 | High when decrement-and-test result is nonzero |

## Verification
The direct path is exercised with a distinct value in each of the eight working registers. This exposes any swap or collapse of register select bits. The indirect path fills locations 8 to 63 through one pointer and reads them back through the other, which separates a wrong pointer choice from a wrong address. Further runs load pointers with the upper bits set and with values below 8; these pick out address masking faults and aliasing faults. Decrement-and-test is run as a short countdown ending at zero and again from 0x00, so the flag's edge and the wrap case are both seen. NOP and unused codes are given nonzero write data and then followed by a full read-back.

// File: rtl/wru_pkg.sv
package wru_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_RD_REG = 3'd1,
    OP_WR_REG = 3'd2,
    OP_RD_IND = 3'd3,
    OP_WR_IND = 3'd4,
    OP_DJNZ   = 3'd5
  } wru_op_e;
endpackage

// File: rtl/wru_ram.sv
module wru_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] ptr0,
  output logic [AW-1:0] ptr1
);
  logic [DEPTH-1:0][DW-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem <= '0;
    else if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
  // pointer taps expose only the address bits; upper bits never reach the decoder
  assign ptr0  = mem[0][AW-1:0];
  assign ptr1  = mem[1][AW-1:0];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wdata));
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/wru_addr_sel.sv
module wru_addr_sel
  import wru_pkg::*;
#(
  parameter int AW  = 6,
  parameter int RSW = 3
) (
  input  logic [2:0]     op,
  input  logic [RSW-1:0] reg_sel,
  input  logic           ind_sel,
  input  logic [AW-1:0]  ptr0,
  input  logic [AW-1:0]  ptr1,
  output logic [AW-1:0]  addr,
  output logic           rd_en,
  output logic           we,
  output logic           use_dec
);
  wru_op_e      opc;
  logic [AW-1:0] reg_addr;
  logic [AW-1:0] ind_addr;

  assign opc      = wru_op_e'(op);
  assign reg_addr = {{(AW-RSW){1'b0}}, reg_sel};
  assign ind_addr = ind_sel ? ptr1 : ptr0;

  always_comb begin
    addr    = reg_addr;
    rd_en   = 1'b0;
    we      = 1'b0;
    use_dec = 1'b0;
    case (opc)
      OP_RD_REG: rd_en = 1'b1;
      OP_WR_REG: begin rd_en = 1'b1; we = 1'b1; end
      OP_RD_IND: begin addr = ind_addr; rd_en = 1'b1; end
      OP_WR_IND: begin addr = ind_addr; rd_en = 1'b1; we = 1'b1; end
      OP_DJNZ:   begin rd_en = 1'b1; we = 1'b1; use_dec = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/wru_dec.sv
module wru_dec #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          nz
);
  assign dout = din - 1'b1;
  assign nz   = |dout;
endmodule

// File: rtl/wreg_ram_unit.sv
module wreg_ram_unit
  import wru_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int NREG  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op,
  input  logic [$clog2(NREG)-1:0] reg_sel,
  input  logic                    ind_sel,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic                    nz_flag
);
  localparam int AW  = $clog2(DEPTH);
  localparam int RSW = $clog2(NREG);

  logic [AW-1:0] addr, ptr0, ptr1;
  logic          rd_en, we, use_dec, dec_nz;
  logic [DW-1:0] ram_rdata, dec_out, wdata;

  wru_addr_sel #(.AW(AW), .RSW(RSW)) u_sel (
    .op(op), .reg_sel(reg_sel), .ind_sel(ind_sel), .ptr0(ptr0), .ptr1(ptr1),
    .addr(addr), .rd_en(rd_en), .we(we), .use_dec(use_dec)
  );

  wru_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(ram_rdata), .ptr0(ptr0), .ptr1(ptr1)
  );

  wru_dec #(.DW(DW)) u_dec (.din(ram_rdata), .dout(dec_out), .nz(dec_nz));

  assign wdata   = use_dec ? dec_out : wr_data;
  assign rd_data = rd_en ? ram_rdata : '0;
  assign nz_flag = use_dec & dec_nz;

  p_nz_only_djnz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nz_flag |-> op == OP_DJNZ);
  p_wrap_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DJNZ && rd_data == '0) |-> nz_flag);
  p_flag_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DJNZ) |-> nz_flag == (rd_data != DW'(1)));
endmodule

// File: tb/tb_wreg_ram_unit.sv
`timescale 1ns/1ps
module tb_wreg_ram_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [2:0] reg_sel = 3'd0;
  logic       ind_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       nz_flag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] m [64];

  always #2.5 clk = ~clk;

  wreg_ram_unit dut (.clk(clk), .rst_n(rst_n), .op(op), .reg_sel(reg_sel),
    .ind_sel(ind_sel), .wr_data(wr_data), .rd_data(rd_data), .nz_flag(nz_flag));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one operation: expected outputs follow the requirement text, model updated after the edge
  task automatic run(input logic [2:0] o, input logic [2:0] s, input bit i,
                     input logic [7:0] w, input string tag);
    logic [5:0] a;
    logic [7:0] erd, nv;
    bit enz, wr;
    a = {3'b000, s}; erd = 8'h00; enz = 0; wr = 0; nv = w;
    case (o)
      3'd1: erd = m[a];
      3'd2: begin erd = m[a]; wr = 1; end
      3'd3: begin a = i ? m[1][5:0] : m[0][5:0]; erd = m[a]; end
      3'd4: begin a = i ? m[1][5:0] : m[0][5:0]; erd = m[a]; wr = 1; end
      3'd5: begin erd = m[a]; nv = m[a] - 8'd1; enz = (nv != 0); wr = 1; end
      default: ;
    endcase
    @(negedge clk);
    op = o; reg_sel = s; ind_sel = i; wr_data = w;
    #1;
    chk(rd_data === erd, {tag, " rd_data"}, rd_data, erd);
    chk(nz_flag === enz, {tag, " nz_flag"}, nz_flag, enz);
    @(posedge clk);
    if (wr) m[a] = nv;
    #1 op = 3'd0;
  endtask

  task automatic read_all_regs(input string tag);
    for (int r = 0; r < 8; r++) run(3'd1, 3'(r), 0, 8'h00, tag);
  endtask

  task automatic t_reset;
    read_all_regs("R1");
    for (int a = 8; a < 64; a += 11) begin
      run(3'd2, 3'd0, 0, 8'(a), "R1 ptr");
      run(3'd3, 3'd0, 0, 8'h00, "R1");
    end
  endtask

  task automatic t_direct;
    for (int r = 0; r < 8; r++) run(3'd2, 3'(r), 0, 8'(8'h31 + r * 8'h17), "R2");
    read_all_regs("R2");
  endtask

  task automatic t_indirect;
    for (int a = 8; a < 64; a++) begin
      run(3'd2, 3'd0, 0, 8'(a), "R3 ptr");
      run(3'd4, 3'd0, 0, 8'(a) ^ 8'hA5, "R3");
    end
    for (int a = 63; a >= 8; a--) begin
      run(3'd2, 3'd1, 0, 8'(a), "R3 ptr");
      run(3'd3, 3'd0, 1, 8'h00, "R3");
    end
  endtask

  task automatic t_ptr_high;
    run(3'd2, 3'd1, 0, 8'hC0 | 8'd20, "R4 ptr");
    run(3'd3, 3'd0, 1, 8'h00, "R4");
    run(3'd2, 3'd0, 0, 8'h80 | 8'd40, "R4 ptr");
    run(3'd4, 3'd0, 0, 8'h3C, "R4");
    run(3'd2, 3'd1, 0, 8'd40, "R4 ptr");
    run(3'd3, 3'd0, 1, 8'h00, "R4");
  endtask

  task automatic t_alias;
    run(3'd2, 3'd0, 0, 8'd5, "R5 ptr");
    run(3'd4, 3'd0, 0, 8'h9E, "R5");
    run(3'd1, 3'd5, 0, 8'h00, "R5");
    run(3'd2, 3'd1, 0, 8'd1, "R5 ptr");
    run(3'd4, 3'd0, 1, 8'd2, "R5 self");
    run(3'd1, 3'd1, 0, 8'h00, "R5");
  endtask

  task automatic t_rmw;
    run(3'd2, 3'd0, 0, 8'd33, "R6 ptr");
    run(3'd4, 3'd0, 0, 8'h11, "R6");
    run(3'd4, 3'd0, 0, 8'h22, "R6");
    run(3'd2, 3'd6, 0, 8'h77, "R6");
    run(3'd2, 3'd6, 0, 8'h78, "R6");
  endtask

  task automatic t_djnz;
    run(3'd2, 3'd3, 0, 8'd3, "R7 load");
    for (int k = 0; k < 3; k++) run(3'd5, 3'd3, 0, 8'h55, "R7");
    run(3'd1, 3'd3, 0, 8'h00, "R7");
  endtask

  task automatic t_wrap;
    run(3'd5, 3'd3, 0, 8'h00, "R8");
    run(3'd1, 3'd3, 0, 8'h00, "R8");
    run(3'd5, 3'd3, 0, 8'h00, "R8 next");
  endtask

  task automatic t_nop;
    run(3'd0, 3'd2, 0, 8'hEE, "R9");
    run(3'd6, 3'd4, 1, 8'hDD, "R9");
    run(3'd7, 3'd7, 0, 8'hCC, "R9");
    read_all_regs("R9");
    run(3'd2, 3'd0, 0, 8'd33, "R9 ptr");
    run(3'd3, 3'd0, 0, 8'h00, "R9");
  endtask

  initial begin
    for (int a = 0; a < 64; a++) m[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_indirect();
    t_ptr_high();
    t_alias();
    t_rmw();
    t_djnz();
    t_wrap();
    t_nop();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule